// File: doc/BRIEF.md
# Lookahead Synchronous FIFO

This block is a single-clock FIFO whose storage is a memory with a registered read port, of the kind that maps onto on-chip block RAM. The output behaves as show-ahead: the oldest stored word sits on the read data port with a valid flag as soon as it is available. The reader does not have to request it first. Asserting read enable while valid is high acknowledges the displayed word, and the next word takes its place on the following cycle.

The one-cycle latency of the memory is hidden in two ways. First, the memory read address is chosen combinationally from the current read pointer, so the fetch of the next word starts on the same edge that consumes the current one. Second, a small bypass register captures the write data whenever the incoming word would become the head in the same cycle, which the memory cannot yet return. Depth is a power of two (default 64) and data width is a parameter.

Top module: `lookahead_fifo`

## Requirements
- R1: A synchronous active-high reset empties the FIFO. After the reset edge, `out_valid` is 0 and `in_full` is 0, and words stored before the reset are discarded.
- R2: A word written into an empty FIFO is shown on `out_data` with `out_valid` high one clock edge after the write edge, with no read enable needed.
- R3: While two or more words are stored and `out_ack` is held high, a new word in write order is presented after every clock edge, with no idle cycle between reads.
- R4: The memory read port is addressed with the incremented read pointer when a read is accepted in a cycle, and otherwise with the current read pointer. As a result, the word after the consumed one is the one shown after the edge.
- R5: `out_valid` is low exactly when the FIFO holds no word. An `out_ack` given while `out_valid` is low is ignored and does not move the read position. A later write followed by a read returns that written word.
- R6: `in_full` is high exactly when the occupancy equals DEPTH. A write while `in_full` is high is ignored, and the stored words drain later unchanged and in order.
- R7: An acknowledge and a write in the same cycle, on a FIFO holding exactly one word, keep `out_valid` high and show the newly written word after that edge.
- R8: An acknowledge and a write in the same cycle at any occupancy from 1 to DEPTH-1 leave the occupancy unchanged and preserve write order.
- R9: Read and write pointers carry one bit more than the address. The occupancy always equals their difference, so full and empty stay distinct even when the addresses match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_push | input | 1 | Write enable |
| in_data | input | WIDTH | Write data |
| in_full | output | 1 | FIFO holds DEPTH words; writes are ignored |
| out_ack | input | 1 | Acknowledge (pop) of the word on out_data |
| out_data | output | WIDTH | Head word, meaningful while out_valid is high |
| out_valid | output | 1 | FIFO holds at least one word |

## Verification
Every result of this block is due one clock edge after the stimulus that causes it. A write into an empty FIFO, an acknowledge, a write that fills the last slot, and a reset all change `out_data`, `out_valid` and `in_full` on the next edge. The bench therefore drives inputs on the falling edge, lets exactly one rising edge pass, and compares all three outputs on the next falling edge. It compares them against a queue model that it updates arithmetically with the same accept rules: a read counts only while the model is non-empty, and a write only while it is below DEPTH. Directed phases cover reads on an empty FIFO, writes on a full FIFO, the one-word read-and-write case, a sweep of simultaneous reads and writes over every occupancy, and a mid-run reset. A long pseudo-random phase follows.

// File: rtl/lookahead_fifo_pkg.sv
package lookahead_fifo_pkg;

  // Which register feeds the output data port.
  typedef enum logic {
    SRC_MEM    = 1'b0,
    SRC_BYPASS = 1'b1
  } head_src_e;

  function automatic bit is_pow2(input int unsigned v);
    return (v >= 2) && ((v & (v - 1)) == 0);
  endfunction

endpackage

// File: rtl/lf_store.sv
// Storage array with one write port and one registered read port.
// Coded so that block RAM can be inferred: no reset on the array or on the read register.
module lf_store #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [WIDTH-1:0] rd_q
);

  logic [WIDTH-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) cells[wr_addr] <= wr_data;
  end

  // Read data follows the sampled address by one edge; never combinational.
  always_ff @(posedge clk) begin
    rd_q <= cells[rd_addr];
  end

endmodule

// File: rtl/lf_ptrs.sv
// Pointer, occupancy and flag control with lookahead read addressing.
module lf_ptrs #(
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_req,
  input  logic          rd_req,
  output logic          push,
  output logic          pop,
  output logic [PW-1:0] wr_ptr,
  output logic [PW-1:0] rd_sel,
  output logic [CW-1:0] occ,
  output logic          valid_q,
  output logic          full_q
);

  logic [PW-1:0] rd_ptr;
  logic [PW-1:0] rd_ptr_inc;
  logic [CW-1:0] occ_nxt;

  // Accept rules: reads need a shown word, writes need a free slot.
  assign push = wr_req & ~full_q;
  assign pop  = rd_req & valid_q;

  assign rd_ptr_inc = rd_ptr + PW'(1);
  // Lookahead: fetch the word after the head on the same edge that consumes it.
  assign rd_sel     = pop ? rd_ptr_inc : rd_ptr;

  always_comb begin
    occ_nxt = occ;
    if (push && !pop)      occ_nxt = occ + CW'(1);
    else if (pop && !push) occ_nxt = occ - CW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      occ     <= '0;
      valid_q <= 1'b0;
      full_q  <= 1'b0;
    end else begin
      if (push) wr_ptr <= wr_ptr + PW'(1);
      rd_ptr  <= rd_sel;
      occ     <= occ_nxt;
      valid_q <= (occ_nxt != '0);
      full_q  <= (occ_nxt == CW'(DEPTH));
    end
  end

  // R9: occupancy tracks the extended-pointer difference every cycle.
  p_occ_ptr_r9: assert property (@(posedge clk) disable iff (rst)
    occ == CW'(wr_ptr - rd_ptr));

  // R5: valid flag mirrors a non-zero occupancy.
  p_valid_occ_r5: assert property (@(posedge clk) disable iff (rst)
    valid_q == (occ != '0));

  // R5: an acknowledge on an empty FIFO leaves the read pointer in place.
  p_empty_ack_ignored_r5: assert property (@(posedge clk) disable iff (rst)
    (!valid_q && rd_req) |=> (rd_ptr == $past(rd_ptr)));

  // R6: full flag mirrors occupancy == DEPTH.
  p_full_depth_r6: assert property (@(posedge clk) disable iff (rst)
    full_q == (occ == CW'(DEPTH)));

  // R6: a write against a full FIFO leaves the write pointer in place.
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
    (full_q && wr_req) |=> (wr_ptr == $past(wr_ptr)));

  // R3: an accepted read always advances the read pointer by one.
  p_read_advance_r3: assert property (@(posedge clk) disable iff (rst)
    pop |=> (rd_ptr == $past(rd_ptr) + PW'(1)));

  // R8: simultaneous accepted read and write keep the occupancy.
  p_rw_keeps_occ_r8: assert property (@(posedge clk) disable iff (rst)
    (push && pop) |=> (occ == $past(occ)));

  // R1: the cycle after a reset edge shows an empty, non-full FIFO.
  p_reset_state_r1: assert property (@(posedge clk)
    $past(rst) |-> (!valid_q && !full_q && occ == '0));

endmodule

// File: rtl/lf_head.sv
// Output stage: chooses between the memory read register and a bypass
// register that holds a word written on the same edge it became the head.
module lf_head
  import lookahead_fifo_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hit,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [WIDTH-1:0] mem_q,
  output logic [WIDTH-1:0] head
);

  head_src_e        src_q;
  logic [WIDTH-1:0] byp_q;

  always_ff @(posedge clk) begin
    if (rst) src_q <= SRC_MEM;
    else     src_q <= hit ? SRC_BYPASS : SRC_MEM;
  end

  always_ff @(posedge clk) begin
    if (hit) byp_q <= wr_data;
  end

  assign head = (src_q == SRC_BYPASS) ? byp_q : mem_q;

  // R7: a word written as it becomes the head appears after that edge.
  p_bypass_head_r7: assert property (@(posedge clk) disable iff (rst)
    hit |=> (head == $past(wr_data)));

endmodule

// File: rtl/lookahead_fifo.sv
module lookahead_fifo
  import lookahead_fifo_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int DEPTH = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_push,
  input  logic [WIDTH-1:0] in_data,
  output logic             in_full,
  input  logic             out_ack,
  output logic [WIDTH-1:0] out_data,
  output logic             out_valid
);

  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;
  localparam int CW = $clog2(DEPTH + 1);

  initial begin
    a_depth_pow2: assert (is_pow2(DEPTH))
      else $error("DEPTH must be a power of two");
  end

  logic          push, pop, valid_q, full_q, hit;
  logic [PW-1:0] wr_ptr, rd_sel;
  logic [CW-1:0] occ;
  logic [WIDTH-1:0] mem_q;

  lf_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk     (clk),
    .rst     (rst),
    .wr_req  (in_push),
    .rd_req  (out_ack),
    .push    (push),
    .pop     (pop),
    .wr_ptr  (wr_ptr),
    .rd_sel  (rd_sel),
    .occ     (occ),
    .valid_q (valid_q),
    .full_q  (full_q)
  );

  lf_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
    .clk     (clk),
    .wr_en   (push),
    .wr_addr (wr_ptr[AW-1:0]),
    .wr_data (in_data),
    .rd_addr (rd_sel[AW-1:0]),
    .rd_q    (mem_q)
  );

  // The incoming word becomes the head on this edge: the memory cannot return it yet.
  assign hit = push && (wr_ptr == rd_sel);

  lf_head #(.WIDTH(WIDTH)) u_head (
    .clk     (clk),
    .rst     (rst),
    .hit     (hit),
    .wr_data (in_data),
    .mem_q   (mem_q),
    .head    (out_data)
  );

  assign out_valid = valid_q;
  assign in_full   = full_q;

  // R2: a write into an empty FIFO falls through to the output.
  p_fall_through_r2: assert property (@(posedge clk) disable iff (rst)
    (!out_valid && in_push) |=> (out_valid && out_data == $past(in_data)));

  // R3: with two or more words, an accepted read leaves a word shown.
  p_back_to_back_r3: assert property (@(posedge clk) disable iff (rst)
    (pop && occ > CW'(1)) |=> out_valid);

  // R7: one stored word, read and write together: valid stays, new word shown.
  p_one_word_rw_r7: assert property (@(posedge clk) disable iff (rst)
    (occ == CW'(1) && out_ack && in_push) |=> (out_valid && out_data == $past(in_data)));

endmodule

// File: tb/tb_lookahead_fifo.sv
module tb_lookahead_fifo;

  localparam int W = 8;
  localparam int D = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_push = 1'b0;
  logic [W-1:0] in_data = '0;
  logic out_ack = 1'b0;
  logic in_full, out_valid;
  logic [W-1:0] out_data;

  always #10 clk = ~clk;   // 50 MHz

  lookahead_fifo #(.WIDTH(W), .DEPTH(D)) dut (
    .clk       (clk),
    .rst       (rst),
    .in_push   (in_push),
    .in_data   (in_data),
    .in_full   (in_full),
    .out_ack   (out_ack),
    .out_data  (out_data),
    .out_valid (out_valid)
  );

  int checks = 0;
  int fails  = 0;
  string cur_req = "R1";
  logic [W-1:0] model[$];
  logic [W-1:0] seq = 8'h10;

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
    end
  endtask

  task automatic check_outputs();
    check(out_valid == (model.size() > 0), "out_valid", int'(out_valid), int'(model.size() > 0));
    check(in_full == (model.size() == D), "in_full", int'(in_full), int'(model.size() == D));
    if (model.size() > 0)
      check(out_data == model[0], "out_data", int'(out_data), int'(model[0]));
  endtask

  // Called on a falling edge; returns on the next falling edge after checking.
  task automatic step(input bit we, input logic [W-1:0] wd, input bit re);
    bit acc_wr, acc_rd;
    in_push = we; in_data = wd; out_ack = re;
    acc_rd = re && (model.size() > 0);
    acc_wr = we && (model.size() < D);
    @(posedge clk);
    if (acc_rd) void'(model.pop_front());
    if (acc_wr) model.push_back(wd);
    @(negedge clk);
    check_outputs();
  endtask

  task automatic put();
    step(1'b1, seq, 1'b0);
    seq = seq + 8'd1;
  endtask

  task automatic drain();
    while (model.size() > 0) step(1'b0, '0, 1'b1);
  endtask

  task automatic do_reset();
    rst = 1'b1; in_push = 1'b0; out_ack = 1'b0;
    @(posedge clk);
    model.delete();
    @(negedge clk);
    rst = 1'b0;
    check(!out_valid, "out_valid after reset", int'(out_valid), 0);
    check(!in_full, "in_full after reset", int'(in_full), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(negedge clk);
    // R1: initial reset
    cur_req = "R1";
    do_reset();

    // R2: fall-through into an empty FIFO without acknowledge
    cur_req = "R2";
    put();
    check(out_valid == 1'b1, "valid without ack", int'(out_valid), 1);
    step(1'b0, '0, 1'b0);
    drain();

    // R5: acknowledges on an empty FIFO are ignored
    cur_req = "R5";
    repeat (4) step(1'b0, '0, 1'b1);
    put(); put();
    drain();

    // R3 R4: back-to-back reads with ack held high
    cur_req = "R3 R4";
    repeat (10) put();
    repeat (10) step(1'b0, '0, 1'b1);
    check(!out_valid, "empty after burst", int'(out_valid), 0);

    // R6: fill to DEPTH, writes while full ignored, drain unchanged
    cur_req = "R6";
    repeat (D) put();
    check(in_full == 1'b1, "full at DEPTH", int'(in_full), 1);
    repeat (3) step(1'b1, 8'hEE, 1'b0);
    drain();

    // R7: one word, simultaneous ack and write, repeated
    cur_req = "R7";
    put();
    for (int i = 0; i < 8; i++) begin
      step(1'b1, seq, 1'b1);
      seq = seq + 8'd1;
    end
    drain();

    // R8 R9: simultaneous ack and write at every occupancy
    cur_req = "R8 R9";
    for (int n = 0; n <= D; n++) begin
      for (int k = 0; k < n; k++) put();
      for (int k = 0; k < 3; k++) begin
        step(1'b1, seq, 1'b1);
        seq = seq + 8'd1;
      end
      drain();
    end

    // R8 R9: pseudo-random traffic
    lfsr = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0] | lfsr[3], lfsr[11:4], lfsr[1] & ~lfsr[7]);
    end

    // R1: reset with words stored discards them
    cur_req = "R1";
    if (model.size() == 0) put();
    do_reset();
    put();
    drain();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule